// File: doc/BRIEF.md
# Stream Boot Record Loader

This block controls the processor's start-up after reset. A two-bit mode input, sampled once on the first clock edge after reset, selects the start-up path. Code 0 means a plain start: the processor is released at once and no loader runs. Each of the other three codes selects one of three byte sources for a stream boot: an asynchronous serial receiver, a clocked serial receiver or a parallel slave port. The matching source enable is driven high for as long as loading runs.

While loading, the block takes bytes from a valid/ready input and groups every three accepted bytes into one record. The first byte is the address high byte, the second is the address low byte and the third is the data byte. Each record becomes one write on a valid/ready write port. Address bit 15 selects the target space: 1 selects internal I/O space and 0 selects memory space. The remaining 15 bits form the write address, so each space can be written only in its first 32K locations.

The first I/O-space write ends the boot. That write completes its handshake first, so it can remap memory before the processor begins to fetch. The release output then goes high, which lets the processor fetch from address zero. It stays high until the next reset.

Back-pressure works as follows. A byte is taken only on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low while a write is waiting on the write port. It is also low before loading starts and after release. A write stays pending, with its fields unchanged, until it sees `wr_ready` high on an edge.

Top module: `boot_triplet_loader`

## Requirements
- R1: While reset is asserted, `cpu_release`, `boot_active`, `in_ready`, `wr_valid` and `src_en` are all 0.
- R2: With mode code 0 at the first edge after reset, `cpu_release` is 1 after that edge and stays 1. `in_ready` stays 0 and no write is issued, even when input bytes are offered.
- R3: With mode code 1, 2 or 3 at the first edge after reset, `boot_active` and `in_ready` are 1 after that edge. `src_en` is one-hot, with bit (code-1) set: bit 0 for asynchronous serial, bit 1 for clocked serial, bit 2 for the slave port.
- R4: Bytes are taken in the order address high, address low, data. On the edge that accepts the third byte of a record, `wr_valid` rises. `wr_addr` is then {high[6:0], low} and `wr_data` is the third byte.
- R5: `wr_io` equals bit 7 of the record's high byte, which is bit 15 of the address: 1 for I/O space, 0 for memory space.
- R6: While `wr_valid` is 1, `in_ready` is 0. While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_io`, `wr_addr` and `wr_data` hold their values.
- R7: An offered byte that meets `in_ready` low, or a data value shown while `in_valid` is 0, does not advance the record byte count. The next three accepted bytes form the next record.
- R8: A memory-space write handshake leaves `cpu_release` at 0 and sets `in_ready` back to 1. An I/O-space write handshake sets `cpu_release` to 1 after that edge. The release then stays 1 until reset, with `boot_active`, `in_ready` and `src_en` at 0.
- R9: Changes on `mode_sel` after the first edge following reset have no effect on `src_en` or on the loading path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Start-up mode code, sampled once after reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Loader can take a byte |
| wr_valid | output | 1 | Write request pending |
| wr_ready | input | 1 | Write target takes the request |
| wr_io | output | 1 | 1 selects I/O space, 0 selects memory space |
| wr_addr | output | 15 | Write address within the selected space |
| wr_data | output | 8 | Write data |
| src_en | output | 3 | One-hot enable of the selected byte source |
| boot_active | output | 1 | Stream loading is in progress |
| cpu_release | output | 1 | Processor may fetch from address zero |

## Verification
Mode decoding, `src_en` and `in_ready` are valid one edge after reset is released. `wr_valid` and the write fields are valid one edge after the third byte is accepted. The bench drives and reads only on falling edges, so each value is read half a cycle after the rising edge that set it. A write handshake clears `wr_valid` on that same edge. For an I/O-space write it also sets `cpu_release`, so the bench checks both at the next falling edge. Each record is also held for two cycles with junk bytes offered, so the bench can check that the fields stay stable and that the junk bytes are dropped.

// File: rtl/loader_pkg.sv
package loader_pkg;
  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_LOAD = 2'd1,
    ST_DONE = 2'd2
  } boot_state_t;
endpackage

// File: rtl/triplet_assembler.sv
module triplet_assembler #(
  parameter int DATA_W    = 8,
  parameter int REC_BYTES = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  accept,
  input  logic [DATA_W-1:0]                     byte_in,
  output logic                                  rec_done,
  output logic [DATA_W*(REC_BYTES-1)-1:0]       rec_addr,
  output logic [DATA_W-1:0]                     rec_data
);
  localparam int ADDR_W = DATA_W * (REC_BYTES - 1);
  localparam int CNT_W  = $clog2(REC_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REC_BYTES - 1);

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      hold <= '0;
    end else if (accept) begin
      if (cnt == LAST) begin
        cnt <= '0;
      end else begin
        cnt  <= cnt + 1'b1;
        hold <= {hold[ADDR_W-DATA_W-1:0], byte_in};
      end
    end
  end

  assign rec_done = accept && (cnt == LAST);
  assign rec_addr = hold;
  assign rec_data = byte_in;
endmodule

// File: rtl/write_issuer.sv
module write_issuer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic              wr_io,
  output logic [ADDR_W-2:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              io_done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_io    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (load) begin
      wr_valid <= 1'b1;
      wr_io    <= addr_in[ADDR_W-1];
      wr_addr  <= addr_in[ADDR_W-2:0];
      wr_data  <= data_in;
    end else if (wr_valid && wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  assign io_done = wr_valid && wr_ready && wr_io;
endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
  import loader_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [MODE_W-1:0]            mode_sel,
  input  logic                         io_done,
  output logic                         loading,
  output logic                         released,
  output logic [(1<<MODE_W)-2:0]       src_en
);
  localparam int SRC_N = (1 << MODE_W) - 1;

  boot_state_t       state;
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_INIT;
      mode_q <= '0;
    end else begin
      case (state)
        ST_INIT: begin
          mode_q <= mode_sel;
          state  <= (mode_sel == '0) ? ST_DONE : ST_LOAD;
        end
        ST_LOAD: if (io_done) state <= ST_DONE;
        default: state <= ST_DONE;
      endcase
    end
  end

  assign loading  = (state == ST_LOAD);
  assign released = (state == ST_DONE);

  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    assign src_en[g] = loading && (mode_q == MODE_W'(g + 1));
  end
endmodule

// File: rtl/boot_triplet_loader.sv
module boot_triplet_loader #(
  parameter int DATA_W = 8,
  parameter int MODE_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [MODE_W-1:0]             mode_sel,
  input  logic                          in_valid,
  input  logic [DATA_W-1:0]             in_data,
  output logic                          in_ready,
  output logic                          wr_valid,
  input  logic                          wr_ready,
  output logic                          wr_io,
  output logic [2*DATA_W-2:0]           wr_addr,
  output logic [DATA_W-1:0]             wr_data,
  output logic [(1<<MODE_W)-2:0]        src_en,
  output logic                          boot_active,
  output logic                          cpu_release
);
  localparam int ADDR_W    = 2 * DATA_W;
  localparam int REC_BYTES = 3;

  logic              accept;
  logic              rec_done;
  logic [ADDR_W-1:0] rec_addr;
  logic [DATA_W-1:0] rec_data;
  logic              io_done;
  logic              loading;

  assign in_ready    = loading && !wr_valid;
  assign accept      = in_valid && in_ready;
  assign boot_active = loading;

  triplet_assembler #(.DATA_W(DATA_W), .REC_BYTES(REC_BYTES)) u_asm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .byte_in(in_data),
    .rec_done(rec_done), .rec_addr(rec_addr), .rec_data(rec_data)
  );

  write_issuer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .load(rec_done), .addr_in(rec_addr),
    .data_in(rec_data), .wr_ready(wr_ready), .wr_valid(wr_valid),
    .wr_io(wr_io), .wr_addr(wr_addr), .wr_data(wr_data), .io_done(io_done)
  );

  boot_sequencer #(.MODE_W(MODE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .io_done(io_done),
    .loading(loading), .released(cpu_release), .src_en(src_en)
  );
endmodule

// File: rtl/loader_checker.sv
module loader_checker #(
  parameter int DATA_W = 8,
  parameter int MODE_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_ready,
  input logic                   wr_valid,
  input logic                   wr_ready,
  input logic                   wr_io,
  input logic [2*DATA_W-2:0]    wr_addr,
  input logic [DATA_W-1:0]      wr_data,
  input logic [(1<<MODE_W)-2:0] src_en,
  input logic                   boot_active,
  input logic                   cpu_release
);
  p_onehot_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_en));

  p_ready_low_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !in_ready);

  p_hold_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_io) && $stable(wr_addr) && $stable(wr_data)));

  p_release_after_io_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_io) |=> cpu_release);

  p_mem_no_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_active && wr_valid && wr_ready && !wr_io) |=> !cpu_release);

  p_release_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_release |=> cpu_release);

  p_quiet_after_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_release |-> (!in_ready && !boot_active && src_en == '0));
endmodule

bind boot_triplet_loader loader_checker #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_io(wr_io), .wr_addr(wr_addr), .wr_data(wr_data),
  .src_en(src_en), .boot_active(boot_active), .cpu_release(cpu_release)
);

// File: tb/sim_boot_triplet_loader.sv
`timescale 1ns/1ps
module sim_boot_triplet_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        in_ready;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic        wr_io;
  logic [14:0] wr_addr;
  logic [7:0]  wr_data;
  logic [2:0]  src_en;
  logic        boot_active;
  logic        cpu_release;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  boot_triplet_loader u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_io(wr_io), .wr_addr(wr_addr), .wr_data(wr_data),
    .src_en(src_en), .boot_active(boot_active), .cpu_release(cpu_release)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode_sel = m; in_valid = 1'b0; wr_ready = 1'b0;
    @(negedge clk);
    chk(!cpu_release && !boot_active && !in_ready && !wr_valid && src_en == 3'd0,
        "R1 reset outputs", {cpu_release, boot_active, in_ready, wr_valid, src_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_data = ~b;
  endtask

  task automatic run_record(input logic [15:0] a, input logic [7:0] d, input bit junk);
    send_byte(a[15:8]);
    if (junk) @(negedge clk);
    send_byte(a[7:0]);
    send_byte(d);
    chk(wr_valid, "R4 wr_valid after third byte", wr_valid, 1);
    chk(wr_addr == a[14:0], "R4 wr_addr", wr_addr, a[14:0]);
    chk(wr_data == d, "R4 wr_data", wr_data, d);
    chk(wr_io == a[15], "R5 wr_io from address bit 15", wr_io, a[15]);
    in_valid = 1'b1; in_data = 8'hEE;
    @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(!in_ready, "R6 in_ready low while pending", in_ready, 0);
    chk(wr_valid && wr_addr == a[14:0] && wr_data == d && wr_io == a[15],
        "R6 fields held without wr_ready", {wr_io, wr_addr, wr_data}, {a, d});
    wr_ready = 1'b1;
    @(negedge clk);
    wr_ready = 1'b0;
    chk(!wr_valid, "R8 wr_valid cleared by handshake", wr_valid, 0);
    if (a[15]) begin
      chk(cpu_release && !boot_active && !in_ready && src_en == 3'd0,
          "R8 release after I/O write", {cpu_release, boot_active, in_ready, src_en}, 6'h20);
    end else begin
      chk(!cpu_release && in_ready, "R8 memory write keeps loading",
          {cpu_release, in_ready}, 1);
    end
  endtask

  initial begin
    // R2: plain start
    do_reset(2'd0);
    chk(cpu_release, "R2 release with mode 0", cpu_release, 1);
    chk(!in_ready && !boot_active && src_en == 3'd0, "R2 no loader with mode 0",
        {in_ready, boot_active, src_en}, 0);
    in_valid = 1'b1;
    for (int k = 0; k < 6; k++) begin in_data = 8'(k * 17); @(negedge clk); end
    in_valid = 1'b0;
    chk(!wr_valid && cpu_release, "R2 offered bytes ignored", {wr_valid, cpu_release}, 1);

    for (int m = 1; m < 4; m++) begin
      do_reset(2'(m));
      chk(boot_active && in_ready && !cpu_release, "R3 loading active",
          {boot_active, in_ready, cpu_release}, 6);
      chk(src_en == 3'(1 << (m - 1)), "R3 source enable", src_en, 1 << (m - 1));
      // R9: later mode change is ignored
      mode_sel = 2'(m ^ 3);
      @(negedge clk);
      chk(src_en == 3'(1 << (m - 1)) && boot_active, "R9 mode change ignored",
          src_en, 1 << (m - 1));
      for (int i = 0; i < 12; i++) begin
        logic [15:0] a;
        logic [7:0]  d;
        a = 16'((i * 16'h0A35 + m * 16'h1111) & 16'h7FFF);
        if (i == 0) a = 16'h0000;
        if (i == 11) a = 16'h7FFF;
        d = 8'(i * 29 + m * 7);
        run_record(a, d, (i % 2) == 1); // R7: junk during pending and gaps
      end
      run_record(16'h8000 | 16'(m * 16'h0123), 8'(m * 5), 1'b0);
      in_valid = 1'b1;
      for (int k = 0; k < 4; k++) begin in_data = 8'(k); @(negedge clk); end
      in_valid = 1'b0;
      chk(!wr_valid && cpu_release, "R8 bytes after release ignored",
          {wr_valid, cpu_release}, 1);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule